// File: doc/BRIEF.md
# Ordered Load/Store Queue with Address Disambiguation

This block holds the memory operations of an out-of-order core between dispatch and the data cache. Each load or store enters once, in program order. It carries a base operand that is either a value or the tag of the instruction that will produce it, a 32-bit offset and a destination tag. A store also carries a data operand that is either a value or a tag. The queue watches the result broadcast bus and captures missing operands when their tags appear there. Its own adder forms the word address from the base and the offset as soon as the base is known.

Entries stay in arrival order. An entry may still go to the cache ahead of older entries once it has been checked against every older entry. A load waits only for an older store to the same address. A store waits for its data and for any older load or store to the same address. An older entry whose address is not yet known counts as a match. One access goes to the cache per cycle, and the oldest eligible entry is chosen. An entry leaves the queue when the cache accepts it, and the younger entries close the gap in order. The cache returns load data one cycle after it accepts a load. The queue forwards that data with the load's destination tag toward the broadcast bus.

Top module: `ldst_order_queue`

## Requirements
- R1: After reset the queue is empty: `mem_req_valid` and `ld_valid` are low and `disp_ready` is high.
- R2: An entry's address is base plus offset modulo 2^32. It is formed as soon as the base is known, and `mem_req_addr` carries it.
- R3: A missing base or store-data operand is captured from the broadcast bus when `bc_valid` is high and `bc_tag` equals the operand's tag. This also holds in the same cycle the entry is dispatched. When an operand is not ready, its tag is taken from the low 6 bits of `disp_base` or `disp_data`.
- R4: A load is eligible once its address is known and no older entry is a store to the same address. An older load to the same address does not hold it back.
- R5: A store is eligible only when its address and data are both known and no older load or store has the same address.
- R6: Any older entry whose address is still unknown blocks every younger entry.
- R7: At most one request is presented per cycle, always for the oldest eligible entry. `mem_req_store` is 1 for a store and 0 for a load.
- R8: The queue holds 8 entries and `disp_ready` is low exactly when all 8 are occupied. A dispatch while full is dropped. An entry is removed only in a cycle where `mem_req_valid` and `mem_req_ready` are both high, and the order of the remaining entries is kept.
- R9: In the cycle after a load is accepted, `ld_valid` is high, `ld_tag` is the load's destination tag and `ld_value` equals `mem_rdata`. An accepted store produces no result. `mem_req_tag` carries the load's destination tag.
- R10: A store request carries its captured data on `mem_req_wdata`. Entries with different known addresses do not hold each other back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | New memory operation from dispatch |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_base_rdy | input | 1 | Base operand holds a value (else a tag in low bits) |
| disp_base | input | 32 | Base value or producer tag |
| disp_offset | input | 32 | Address offset |
| disp_data_rdy | input | 1 | Store data holds a value (else a tag in low bits) |
| disp_data | input | 32 | Store data value or producer tag |
| disp_dest_tag | input | 6 | Destination tag of a load |
| disp_ready | output | 1 | Queue has a free entry |
| bc_valid | input | 1 | Broadcast bus carries a result |
| bc_tag | input | 6 | Tag of the broadcast result |
| bc_value | input | 32 | Broadcast result value |
| mem_req_valid | output | 1 | Cache request present |
| mem_req_store | output | 1 | Request is a store |
| mem_req_addr | output | 32 | Word address of the request |
| mem_req_wdata | output | 32 | Store data |
| mem_req_tag | output | 6 | Destination tag of the entry |
| mem_req_ready | input | 1 | Cache accepts the request this cycle |
| mem_rdata | input | 32 | Load data, valid the cycle after acceptance |
| ld_valid | output | 1 | Load result present |
| ld_tag | output | 6 | Destination tag of the result |
| ld_value | output | 32 | Load result value |

## Verification
A wrong conflict decision or a lost operand shows on the cache request port in the same cycle. Either the wrong entry is presented, or a request appears too early or not at all. A bad compaction or count shows within a cycle or two as a wrong address, wrong data or a wrong `disp_ready`. A bench model of the queue, built from plain lists, predicts the request, the ready flag and the load result every cycle. Directed sequences target each ordering hazard, and a long random phase with colliding addresses and tags is added.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;
    localparam int XLEN  = 32;
    localparam int TAG_W = 6;

    typedef struct packed {
        logic             is_store;
        logic             addr_known;
        logic [XLEN-1:0]  addr;
        logic [TAG_W-1:0] base_tag;
        logic [XLEN-1:0]  offset;
        logic             data_rdy;
        logic [XLEN-1:0]  data;
        logic [TAG_W-1:0] data_tag;
        logic [TAG_W-1:0] dest_tag;
    } lsq_entry_t;
endpackage

// File: rtl/lsq_capture.sv
`timescale 1ns/1ps
// Operand capture and address adder for one entry.
module lsq_capture
    import lsq_pkg::*;
(
    input  lsq_entry_t       ent_i,
    input  logic             ext_vld_i,
    input  logic [XLEN-1:0]  ext_base_i,
    input  logic             bc_valid_i,
    input  logic [TAG_W-1:0] bc_tag_i,
    input  logic [XLEN-1:0]  bc_value_i,
    output lsq_entry_t       ent_o
);
    logic            base_hit;
    logic            data_hit;
    logic [XLEN-1:0] base_src;

    always_comb begin
        ent_o    = ent_i;
        base_hit = !ent_i.addr_known && bc_valid_i && (bc_tag_i == ent_i.base_tag);
        data_hit = !ent_i.data_rdy && bc_valid_i && (bc_tag_i == ent_i.data_tag);
        base_src = ext_vld_i ? ext_base_i : bc_value_i;
        if (!ent_i.addr_known && (ext_vld_i || base_hit)) begin
            ent_o.addr_known = 1'b1;
            ent_o.addr       = base_src + ent_i.offset;
        end
        if (data_hit) begin
            ent_o.data_rdy = 1'b1;
            ent_o.data     = bc_value_i;
        end
    end
endmodule

// File: rtl/lsq_pick.sv
`timescale 1ns/1ps
// Conflict check against older entries and oldest-first selection.
module lsq_pick
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lsq_entry_t       ent_i [DEPTH],
    input  logic [CNT_W-1:0] cnt_i,
    output logic             grant_any_o,
    output logic [IDX_W-1:0] sel_o
);
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] blocked;
    logic [DEPTH-1:0] elig;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            live[i]    = (i < int'(cnt_i));
            blocked[i] = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (!ent_i[j].addr_known ||
                    ((ent_i[j].addr == ent_i[i].addr) &&
                     (ent_i[i].is_store || ent_i[j].is_store)))
                    blocked[i] = 1'b1;
            end
            elig[i] = live[i] && ent_i[i].addr_known &&
                      (!ent_i[i].is_store || ent_i[i].data_rdy) && !blocked[i];
        end
    end

    always_comb begin
        grant_any_o = 1'b0;
        sel_o       = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && !grant_any_o) begin
                grant_any_o = 1'b1;
                sel_o       = IDX_W'(i);
            end
        end
    end

    p_grant_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any_o |-> ent_i[sel_o].addr_known);
    p_grant_stdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_any_o && ent_i[sel_o].is_store) |-> ent_i[sel_o].data_rdy);
    p_grant_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any_o |-> (cnt_i != '0));
endmodule

// File: rtl/ldst_order_queue.sv
`timescale 1ns/1ps
module ldst_order_queue
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             disp_is_store,
    input  logic             disp_base_rdy,
    input  logic [XLEN-1:0]  disp_base,
    input  logic [XLEN-1:0]  disp_offset,
    input  logic             disp_data_rdy,
    input  logic [XLEN-1:0]  disp_data,
    input  logic [TAG_W-1:0] disp_dest_tag,
    output logic             disp_ready,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic [XLEN-1:0]  bc_value,
    output logic             mem_req_valid,
    output logic             mem_req_store,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [XLEN-1:0]  mem_req_wdata,
    output logic [TAG_W-1:0] mem_req_tag,
    input  logic             mem_req_ready,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             ld_valid,
    output logic [TAG_W-1:0] ld_tag,
    output logic [XLEN-1:0]  ld_value
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        lsq_entry_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]       cnt;
        logic                   ld_vld;
        logic [TAG_W-1:0]       ld_tag;
    } lsq_state_t;

    lsq_state_t st_d, st_q;

    lsq_entry_t       cur [DEPTH];
    lsq_entry_t       upd [DEPTH];
    lsq_entry_t       raw_in;
    lsq_entry_t       new_in;
    lsq_entry_t       sel_ent;
    logic             req_any;
    logic [IDX_W-1:0] sel_idx;
    logic             accept;
    logic             push;
    logic [CNT_W-1:0] cnt_after;

    always_comb begin
        for (int k = 0; k < DEPTH; k++) cur[k] = st_q.ent[k];
    end

    // Snoop and address formation for every held entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cap
        lsq_capture u_cap (
            .ent_i      (cur[g]),
            .ext_vld_i  (1'b0),
            .ext_base_i ('0),
            .bc_valid_i (bc_valid),
            .bc_tag_i   (bc_tag),
            .bc_value_i (bc_value),
            .ent_o      (upd[g])
        );
    end

    // Incoming entry, before capture.
    always_comb begin
        raw_in            = '0;
        raw_in.is_store   = disp_is_store;
        raw_in.base_tag   = disp_base[TAG_W-1:0];
        raw_in.offset     = disp_offset;
        raw_in.data_rdy   = !disp_is_store || disp_data_rdy;
        raw_in.data       = disp_data;
        raw_in.data_tag   = disp_data[TAG_W-1:0];
        raw_in.dest_tag   = disp_dest_tag;
    end

    lsq_capture u_cap_in (
        .ent_i      (raw_in),
        .ext_vld_i  (disp_base_rdy),
        .ext_base_i (disp_base),
        .bc_valid_i (bc_valid),
        .bc_tag_i   (bc_tag),
        .bc_value_i (bc_value),
        .ent_o      (new_in)
    );

    lsq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .ent_i       (cur),
        .cnt_i       (st_q.cnt),
        .grant_any_o (req_any),
        .sel_o       (sel_idx)
    );

    assign sel_ent       = cur[sel_idx];
    assign disp_ready    = (st_q.cnt != CNT_W'(DEPTH));
    assign mem_req_valid = req_any;
    assign mem_req_store = sel_ent.is_store;
    assign mem_req_addr  = sel_ent.addr;
    assign mem_req_wdata = sel_ent.data;
    assign mem_req_tag   = sel_ent.dest_tag;
    assign ld_valid      = st_q.ld_vld;
    assign ld_tag        = st_q.ld_tag;
    assign ld_value      = mem_rdata;

    assign accept    = req_any && mem_req_ready;
    assign push      = disp_valid && disp_ready;
    assign cnt_after = st_q.cnt - CNT_W'(accept);

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < DEPTH; k++) begin
            int src;
            src = k;
            if (accept && (k >= int'(sel_idx)) && (k + 1 < DEPTH)) src = k + 1;
            st_d.ent[k] = upd[src];
            if (push && (k == int'(cnt_after))) st_d.ent[k] = new_in;
        end
        st_d.cnt    = cnt_after + CNT_W'(push);
        st_d.ld_vld = accept && !sel_ent.is_store;
        st_d.ld_tag = sel_ent.dest_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready && !accept) |=> !disp_ready);
    p_ld_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mem_req_store) |=> ld_valid);
    p_st_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mem_req_store) |=> !ld_valid);
    p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> !mem_req_valid);
endmodule

// File: tb/ldst_order_queue_bench.sv
`timescale 1ns/1ps
module ldst_order_queue_bench;
    import lsq_pkg::*;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic disp_valid, disp_is_store, disp_base_rdy, disp_data_rdy;
    logic [31:0] disp_base, disp_offset, disp_data;
    logic [5:0]  disp_dest_tag;
    logic disp_ready;
    logic bc_valid;
    logic [5:0]  bc_tag;
    logic [31:0] bc_value;
    logic mem_req_valid, mem_req_store, mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata;
    logic [5:0]  mem_req_tag;
    logic ld_valid;
    logic [5:0]  ld_tag;
    logic [31:0] ld_value;

    ldst_order_queue #(.DEPTH(DEPTH)) u_ldst_order_queue (.*);

    typedef struct {
        bit          st;
        bit          ak;
        logic [31:0] addr;
        logic [5:0]  btag;
        logic [31:0] off;
        bit          dr;
        logic [31:0] data;
        logic [5:0]  dtag;
        logic [5:0]  dest;
    } ment_t;

    ment_t       mq[$];
    bit          pend_ld;
    logic [5:0]  pend_tag;
    logic [31:0] pend_val;
    logic [31:0] mem [bit [31:0]];
    int checks = 0;
    int fails  = 0;
    string ctx = "";

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, ctx, act, exp);
        end
    endtask

    function automatic int pick_model();
        for (int i = 0; i < mq.size(); i++) begin
            bit blk;
            if (!mq[i].ak) continue;
            if (mq[i].st && !mq[i].dr) continue;
            blk = 0;
            for (int j = 0; j < i; j++)
                if (!mq[j].ak || (mq[j].addr == mq[i].addr && (mq[i].st || mq[j].st))) blk = 1;
            if (!blk) return i;
        end
        return -1;
    endfunction

    task automatic idle_inputs();
        disp_valid = 0; disp_is_store = 0; disp_base_rdy = 0; disp_data_rdy = 0;
        disp_base = 0; disp_offset = 0; disp_data = 0; disp_dest_tag = 0;
        bc_valid = 0; bc_tag = 0; bc_value = 0;
    endtask

    task automatic dsp(bit st, bit brdy, logic [31:0] base, logic [31:0] off,
                       bit drdy, logic [31:0] data, logic [5:0] dest);
        disp_valid = 1; disp_is_store = st; disp_base_rdy = brdy; disp_base = base;
        disp_offset = off; disp_data_rdy = drdy; disp_data = data; disp_dest_tag = dest;
    endtask

    task automatic bcast(logic [5:0] t, logic [31:0] v);
        bc_valid = 1; bc_tag = t; bc_value = v;
    endtask

    // One clock: compare outputs to the model, then advance the model.
    task automatic cycle();
        int    sel;
        bit    rdy;
        ment_t e;
        mem_rdata = pend_ld ? pend_val : 32'h0;
        #1;
        sel = pick_model();
        rdy = (mq.size() < DEPTH);
        chk(mem_req_valid == (sel >= 0), "R7 valid", 32'(mem_req_valid), 32'(sel >= 0));
        if (sel >= 0 && mem_req_valid) begin
            chk(mem_req_addr == mq[sel].addr, "R2 addr", mem_req_addr, mq[sel].addr);
            chk(mem_req_store == mq[sel].st, "R7 kind", 32'(mem_req_store), 32'(mq[sel].st));
            if (mq[sel].st)
                chk(mem_req_wdata == mq[sel].data, "R10 wdata", mem_req_wdata, mq[sel].data);
            else
                chk(mem_req_tag == mq[sel].dest, "R9 reqtag", 32'(mem_req_tag), 32'(mq[sel].dest));
        end
        chk(disp_ready == rdy, "R8 ready", 32'(disp_ready), 32'(rdy));
        chk(ld_valid == pend_ld, "R9 ldvalid", 32'(ld_valid), 32'(pend_ld));
        if (pend_ld) begin
            chk(ld_tag == pend_tag, "R9 ldtag", 32'(ld_tag), 32'(pend_tag));
            chk(ld_value == pend_val, "R9 ldvalue", ld_value, pend_val);
        end
        pend_ld = 0;
        if (sel >= 0 && mem_req_ready) begin
            if (mq[sel].st) mem[mq[sel].addr] = mq[sel].data;
            else begin
                pend_ld  = 1;
                pend_tag = mq[sel].dest;
                pend_val = mem.exists(mq[sel].addr) ? mem[mq[sel].addr] : 32'h0;
            end
        end
        for (int i = 0; i < mq.size(); i++) begin
            if (!mq[i].ak && bc_valid && bc_tag == mq[i].btag) begin
                mq[i].ak = 1; mq[i].addr = bc_value + mq[i].off;
            end
            if (!mq[i].dr && bc_valid && bc_tag == mq[i].dtag) begin
                mq[i].dr = 1; mq[i].data = bc_value;
            end
        end
        if (sel >= 0 && mem_req_ready) mq.delete(sel);
        if (disp_valid && rdy) begin
            e.st = disp_is_store; e.off = disp_offset; e.dest = disp_dest_tag;
            e.btag = disp_base[5:0]; e.dtag = disp_data[5:0]; e.addr = 0; e.data = disp_data;
            e.ak = 0; e.dr = 0;
            if (disp_base_rdy) begin e.ak = 1; e.addr = disp_base + disp_offset; end
            else if (bc_valid && bc_tag == e.btag) begin e.ak = 1; e.addr = bc_value + disp_offset; end
            if (!e.st || disp_data_rdy) e.dr = 1;
            else if (bc_valid && bc_tag == e.dtag) begin e.dr = 1; e.data = bc_value; end
            mq.push_back(e);
        end
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        idle_inputs();
        mem_req_ready = 0; mem_rdata = 0; pend_ld = 0; pend_tag = 0; pend_val = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        ctx = "R1 reset";
        chk(mem_req_valid == 0, "R1 req", 32'(mem_req_valid), 0);
        chk(disp_ready == 1, "R1 ready", 32'(disp_ready), 1);
        chk(ld_valid == 0, "R1 ld", 32'(ld_valid), 0);
        @(negedge clk);

        ctx = "R2 R9 R10 basic";
        mem_req_ready = 1;
        dsp(1, 1, 100, 4, 1, 32'hAA, 1); cycle();
        dsp(0, 1, 96, 8, 0, 0, 2); cycle();
        dsp(0, 1, 32'hFFFF_FFF0, 32'h20, 0, 0, 3); cycle();
        repeat (4) cycle();

        ctx = "R4 load vs older store";
        mem_req_ready = 0;
        dsp(1, 1, 200, 0, 0, 7, 3); cycle();
        dsp(0, 1, 200, 0, 0, 0, 4); cycle();
        dsp(0, 1, 300, 0, 0, 0, 5); cycle();
        dsp(0, 1, 300, 0, 0, 0, 6); cycle();
        mem_req_ready = 1;
        repeat (3) cycle();
        bcast(7, 32'h55); cycle();
        repeat (4) cycle();

        ctx = "R6 unknown older address";
        dsp(0, 0, 9, 4, 0, 0, 6); cycle();
        dsp(0, 1, 400, 0, 0, 0, 7); cycle();
        repeat (3) cycle();
        bcast(9, 396); cycle();
        repeat (4) cycle();

        ctx = "R3 same-cycle capture";
        dsp(1, 0, 12, 0, 0, 13, 8); bcast(12, 500); cycle();
        repeat (2) cycle();
        dsp(0, 0, 13, 0, 0, 0, 9); bcast(13, 32'h77); cycle();
        repeat (4) cycle();

        ctx = "R5 store ordering";
        mem_req_ready = 0;
        dsp(1, 1, 600, 0, 0, 21, 9); cycle();
        dsp(0, 1, 600, 0, 0, 0, 10); cycle();
        dsp(1, 1, 600, 0, 1, 32'h11, 11); cycle();
        dsp(1, 1, 700, 0, 1, 32'h22, 12); cycle();
        mem_req_ready = 1;
        repeat (3) cycle();
        bcast(21, 32'h99); cycle();
        repeat (6) cycle();

        ctx = "R8 full queue";
        mem_req_ready = 0;
        for (int k = 0; k < 10; k++) begin
            dsp(0, 1, 1000 + 4 * k, 0, 0, 0, 6'(k)); cycle();
        end
        for (int k = 0; k < 20; k++) begin
            mem_req_ready = k[0];
            if (k % 3 == 0) dsp(1, 1, 1004, 0, 1, 32'(k), 6'(k));
            cycle();
        end

        ctx = "R7 R10 random mix";
        for (int n = 0; n < 500; n++) begin
            mem_req_ready = ($urandom % 4) != 0;
            if ($urandom % 2) begin
                bit brdy;
                brdy = $urandom % 2;
                dsp($urandom % 2, brdy, brdy ? 32'(($urandom % 8) * 4) : 32'($urandom % 8),
                    32'(($urandom % 2) * 4), $urandom % 2, 32'($urandom % 8), 6'($urandom % 64));
            end
            if ($urandom % 2) bcast(6'($urandom % 8), 32'(($urandom % 8) * 4));
            cycle();
        end
        mem_req_ready = 1;
        for (int n = 0; n < 40; n++) begin
            bcast(6'(n % 8), 32'(n * 4));
            cycle();
        end
        finish_run();
    end
endmodule